// File: doc/BRIEF.md
# Prefixed Shift and Bit-Manipulation Unit

This unit executes the second byte of a two-byte prefixed instruction on an 8-bit CPU. That byte is the sub-opcode. The unit covers three shifts (arithmetic left, arithmetic right, logical right) and three single-bit operations (test, clear, set). The operand is either one of seven 8-bit registers or the memory byte addressed by the 16-bit HL pair. The surrounding core presents the sub-opcode with a one-cycle `start` strobe.

For a register operand, the unit reads through a combinational register-file read port in the start cycle. One cycle later it writes the result back and updates the flags. For a memory operand it runs a read-modify-write on a synchronous memory port: a read cycle, a compute cycle, then a write cycle. The completion strobe comes with the write.

Sub-opcodes whose top two bits are zero and that fall outside the three shift groups are rejected with a one-cycle `illegal` pulse. They have no other effect. The flags byte uses bit 7 for Z, bit 6 for N (subtract), bit 5 for H (half-carry) and bit 4 for C (carry), and its low nibble is always zero.

Top module: `pfx_bitops_unit`

## Requirements
- R1: The sub-opcode is decoded in fields. Bits 7:6 give the class: 01 is test, 10 is clear, 11 is set, and 00 is the shift/other group. Bits 5:3 give the bit index. Bits 2:0 give the operand code. Codes 0,1,2,3,4,5,7 name registers B,C,D,E,H,L,A; the register-file select equals the code. Code 6 names the memory byte at HL.
- R2: Sub-opcodes 0x20..0x27 shift left. The result is the operand shifted left with bit 0 filled by zero, and C takes the old bit 7.
- R3: Sub-opcodes 0x28..0x2F shift right arithmetically. Bit 7 is kept, and C takes the old bit 0.
- R4: Sub-opcodes 0x38..0x3F shift right logically. Bit 7 is filled by zero, and C takes the old bit 0.
- R5: Every shift writes flags with Z set exactly when the result is zero, and with N and H cleared. The flags byte has Z, N, H, C in bits 7, 6, 5, 4, and bits 3:0 of `flags_out` are always zero.
- R6: A bit test writes flags with Z set when the selected bit is 0, N = 0, H = 1, and C copied from `flags_in` bit 4. It writes no data to the registers or to memory.
- R7: Bit clear and bit set write the operand back with only the selected bit changed. They do not assert `flags_we`.
- R8: For a register operand, `done`, the register write and the flags write appear in the single cycle right after the start cycle.
- R9: For a memory operand, `mem_rd_en` is asserted with `mem_addr` equal to HL in the first cycle after start. `done`, together with the flag write or the memory write to the same address, appears in the third cycle after start. A bit test reads memory but never writes it.
- R10: A class-00 sub-opcode outside the three shift groups pulses `illegal` for one cycle, one cycle after start. It produces no `done`, no register write, no memory write and no flag write.
- R11: After reset, `done`, `illegal`, `rf_wr_en`, `mem_rd_en`, `mem_wr_en` and `flags_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe: `subop` is valid |
| subop | input | 8 | Sub-opcode (second instruction byte) |
| hl | input | 16 | HL pair, the address for a memory operand |
| rf_rd_sel | output | 3 | Register-file read select (operand code) |
| rf_rd_data | input | 8 | Register-file read data, combinational from `rf_rd_sel` |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wr_sel | output | 3 | Register-file write select |
| rf_wr_data | output | 8 | Register-file write data |
| mem_addr | output | 16 | Memory address |
| mem_rd_en | output | 1 | Memory read strobe; data is expected one cycle later |
| mem_rdata | input | 8 | Memory read data |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| flags_in | input | 8 | Current flags byte |
| flags_we | output | 1 | Flags write strobe |
| flags_out | output | 8 | New flags byte |
| done | output | 1 | Completion pulse for legal operations |
| illegal | output | 1 | Rejection pulse for illegal sub-opcodes |

## Verification
The assertions assume that `start` is raised only while the unit is idle. They also assume that `rf_rd_data` follows `rf_rd_sel` within the same cycle, and that `mem_rdata` is valid in the cycle after `mem_rd_en` and is held afterwards. `hl` and `flags_in` must not change while an operation is in flight. The stimulus leaves several idle cycles after each start, so a memory operation always finishes before the next one begins. The register, memory and flag models update only on the write strobes, so the sampled inputs stay stable. The stimulus sweeps all 256 sub-opcodes with changing operand values and both carry states. It then covers directed corner values: results that become zero, the sign bit in arithmetic shifts, and every bit index on a memory operand.

// File: rtl/pfx_bitops_pkg.sv
package pfx_bitops_pkg;

    localparam int DW     = 8;   // operand and sub-opcode width
    localparam int AW     = 16;  // memory address width
    localparam int SELW   = 3;   // operand-code width
    localparam int IDXW   = $clog2(DW);
    localparam int NIB    = DW / 2;

    localparam logic [SELW-1:0] MEM_SLOT = 3'd6;

    // flag bit positions
    localparam int FZ = 7;
    localparam int FN = 6;
    localparam int FH = 5;
    localparam int FC = 4;

    typedef enum logic [2:0] {
        K_SLA, K_SRA, K_SRL, K_TST, K_CLR, K_SET, K_BAD
    } kind_e;

    typedef enum logic [1:0] {
        PH_IDLE, PH_RD, PH_CALC, PH_WR
    } phase_e;

    typedef struct packed {
        kind_e           kind;
        logic [IDXW-1:0] bidx;
        logic [SELW-1:0] slot;
        logic            mem;
    } dec_t;

    typedef struct packed {
        logic [DW-1:0] val;
        logic [DW-1:0] flg;
        logic          wr_val;
        logic          wr_flg;
    } alu_res_t;

    function automatic logic [DW-1:0] mk_flags(input logic z, input logic n,
                                               input logic h, input logic c);
        logic [DW-1:0] f;
        f     = '0;
        f[FZ] = z;
        f[FN] = n;
        f[FH] = h;
        f[FC] = c;
        return f;
    endfunction

    function automatic kind_e shift_kind(input logic [2:0] grp);
        case (grp)
            3'b100:  return K_SLA;
            3'b101:  return K_SRA;
            3'b111:  return K_SRL;
            default: return K_BAD;
        endcase
    endfunction

endpackage

// File: rtl/pfx_decode.sv
module pfx_decode
    import pfx_bitops_pkg::*;
(
    input  logic [DW-1:0] subop,
    output dec_t          dec
);
    always_comb begin
        dec.bidx = subop[5:3];
        dec.slot = subop[2:0];
        dec.mem  = (subop[2:0] == MEM_SLOT);
        case (subop[7:6])
            2'b01:   dec.kind = K_TST;
            2'b10:   dec.kind = K_CLR;
            2'b11:   dec.kind = K_SET;
            default: dec.kind = shift_kind(subop[5:3]);
        endcase
    end
endmodule

// File: rtl/pfx_bit_alu.sv
module pfx_bit_alu
    import pfx_bitops_pkg::*;
(
    input  dec_t          dec,
    input  logic [DW-1:0] opv,
    input  logic [DW-1:0] flags_in,
    output alu_res_t      res
);
    logic [DW-1:0] mask;
    logic          bit_val;
    logic [DW-1:0] shv;
    logic          sh_c;

    for (genvar g = 0; g < DW; g++) begin : g_mask
        assign mask[g] = (dec.bidx == IDXW'(g));
    end

    assign bit_val = |(opv & mask);

    always_comb begin
        shv  = opv;
        sh_c = 1'b0;
        case (dec.kind)
            K_SLA: begin
                shv  = {opv[DW-2:0], 1'b0};
                sh_c = opv[DW-1];
            end
            K_SRA: begin
                shv  = {opv[DW-1], opv[DW-1:1]};
                sh_c = opv[0];
            end
            K_SRL: begin
                shv  = {1'b0, opv[DW-1:1]};
                sh_c = opv[0];
            end
            default: ;
        endcase
    end

    always_comb begin
        res.val    = opv;
        res.flg    = '0;
        res.wr_val = 1'b0;
        res.wr_flg = 1'b0;
        case (dec.kind)
            K_SLA, K_SRA, K_SRL: begin
                res.val    = shv;
                res.flg    = mk_flags(shv == '0, 1'b0, 1'b0, sh_c);
                res.wr_val = 1'b1;
                res.wr_flg = 1'b1;
            end
            K_TST: begin
                res.flg    = mk_flags(!bit_val, 1'b0, 1'b1, flags_in[FC]);
                res.wr_flg = 1'b1;
            end
            K_CLR: begin
                res.val    = opv & ~mask;
                res.wr_val = 1'b1;
            end
            K_SET: begin
                res.val    = opv | mask;
                res.wr_val = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pfx_seq.sv
module pfx_seq
    import pfx_bitops_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   is_mem,
    input  logic   is_bad,
    output phase_e phase,
    output logic   fire_reg,
    output logic   fire_bad,
    output logic   launch_mem,
    output logic   in_calc
);
    phase_e ph_q;
    logic   idle;

    assign idle       = (ph_q == PH_IDLE);
    assign fire_bad   = start && idle && is_bad;
    assign fire_reg   = start && idle && !is_bad && !is_mem;
    assign launch_mem = start && idle && !is_bad && is_mem;
    assign in_calc    = (ph_q == PH_CALC);
    assign phase      = ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_IDLE;
        end else begin
            case (ph_q)
                PH_IDLE: if (launch_mem) ph_q <= PH_RD;
                PH_RD:   ph_q <= PH_CALC;
                PH_CALC: ph_q <= PH_WR;
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // R9
    seq_calc_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_CALC) |-> $past(ph_q) == PH_RD);

    // R9
    seq_wr_after_calc_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_WR) |-> $past(ph_q) == PH_CALC);
endmodule

// File: rtl/pfx_bitops_unit.sv
module pfx_bitops_unit
    import pfx_bitops_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [DW-1:0]   subop,
    input  logic [AW-1:0]   hl,
    output logic [SELW-1:0] rf_rd_sel,
    input  logic [DW-1:0]   rf_rd_data,
    output logic            rf_wr_en,
    output logic [SELW-1:0] rf_wr_sel,
    output logic [DW-1:0]   rf_wr_data,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_rd_en,
    input  logic [DW-1:0]   mem_rdata,
    output logic            mem_wr_en,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   flags_in,
    output logic            flags_we,
    output logic [DW-1:0]   flags_out,
    output logic            done,
    output logic            illegal
);
    dec_t     dec_live, dec_q, alu_dec;
    alu_res_t res;
    logic [DW-1:0] alu_in;
    phase_e   phase;
    logic     fire_reg, fire_bad, launch_mem, in_calc;

    logic            done_q, illegal_q, rf_we_q, mem_rd_q, mem_wr_q, flags_we_q;
    logic [SELW-1:0] rf_sel_q;
    logic [DW-1:0]   wdata_q, flags_q;
    logic [AW-1:0]   addr_q;

    pfx_decode u_dec (
        .subop (subop),
        .dec   (dec_live)
    );

    pfx_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .is_mem     (dec_live.mem),
        .is_bad     (dec_live.kind == K_BAD),
        .phase      (phase),
        .fire_reg   (fire_reg),
        .fire_bad   (fire_bad),
        .launch_mem (launch_mem),
        .in_calc    (in_calc)
    );

    always_comb begin
        alu_dec = in_calc ? dec_q     : dec_live;
        alu_in  = in_calc ? mem_rdata : rf_rd_data;
    end

    pfx_bit_alu u_alu (
        .dec      (alu_dec),
        .opv      (alu_in),
        .flags_in (flags_in),
        .res      (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q     <= 1'b0;
            illegal_q  <= 1'b0;
            rf_we_q    <= 1'b0;
            mem_rd_q   <= 1'b0;
            mem_wr_q   <= 1'b0;
            flags_we_q <= 1'b0;
            rf_sel_q   <= '0;
            wdata_q    <= '0;
            flags_q    <= '0;
            addr_q     <= '0;
            dec_q      <= '{kind: K_BAD, bidx: '0, slot: '0, mem: 1'b0};
        end else begin
            done_q     <= 1'b0;
            illegal_q  <= 1'b0;
            rf_we_q    <= 1'b0;
            mem_rd_q   <= 1'b0;
            mem_wr_q   <= 1'b0;
            flags_we_q <= 1'b0;
            if (fire_bad) begin
                illegal_q <= 1'b1;
            end
            if (fire_reg) begin
                done_q     <= 1'b1;
                rf_we_q    <= res.wr_val;
                rf_sel_q   <= dec_live.slot;
                wdata_q    <= res.val;
                flags_we_q <= res.wr_flg;
                if (res.wr_flg) flags_q <= res.flg;
            end
            if (launch_mem) begin
                dec_q    <= dec_live;
                addr_q   <= hl;
                mem_rd_q <= 1'b1;
            end
            if (in_calc) begin
                done_q     <= 1'b1;
                mem_wr_q   <= res.wr_val;
                wdata_q    <= res.val;
                flags_we_q <= res.wr_flg;
                if (res.wr_flg) flags_q <= res.flg;
            end
        end
    end

    assign rf_rd_sel  = dec_live.slot;
    assign rf_wr_en   = rf_we_q;
    assign rf_wr_sel  = rf_sel_q;
    assign rf_wr_data = wdata_q;
    assign mem_addr   = addr_q;
    assign mem_rd_en  = mem_rd_q;
    assign mem_wr_en  = mem_wr_q;
    assign mem_wdata  = wdata_q;
    assign flags_we   = flags_we_q;
    assign flags_out  = flags_q;
    assign done       = done_q;
    assign illegal    = illegal_q;

    // R5
    flags_low_nibble_chk: assert property (@(posedge clk) disable iff (rst)
        flags_out[NIB-1:0] == '0);

    // R10
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !done && !rf_wr_en && !mem_wr_en && !flags_we);

    // R8
    reg_write_timing_chk: assert property (@(posedge clk) disable iff (rst)
        rf_wr_en |-> done && $past(start));

    // R9
    mem_wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> done && $past(mem_rd_en, 2));

    // R9
    mem_wr_addr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> mem_addr == $past(hl, 3));

    // R6
    test_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (flags_we && !rf_wr_en && !mem_wr_en) |-> flags_out[FH] && !flags_out[FN]);

    // R1
    no_dual_write_chk: assert property (@(posedge clk) disable iff (rst)
        !(rf_wr_en && mem_wr_en));
endmodule

// File: tb/tb_pfx_bitops_unit.sv
module tb_pfx_bitops_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  subop = '0;
    logic [15:0] hl = '0;
    logic [2:0]  rf_rd_sel;
    logic [7:0]  rf_rd_data;
    logic        rf_wr_en;
    logic [2:0]  rf_wr_sel;
    logic [7:0]  rf_wr_data;
    logic [15:0] mem_addr;
    logic        mem_rd_en;
    logic [7:0]  mem_rdata = '0;
    logic        mem_wr_en;
    logic [7:0]  mem_wdata;
    logic [7:0]  flags_r = '0;
    logic        flags_we;
    logic [7:0]  flags_out;
    logic        done;
    logic        illegal;

    always #10 clk = ~clk;  // 50 MHz

    pfx_bitops_unit dut (
        .clk(clk), .rst(rst), .start(start), .subop(subop), .hl(hl),
        .rf_rd_sel(rf_rd_sel), .rf_rd_data(rf_rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_sel(rf_wr_sel), .rf_wr_data(rf_wr_data),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata),
        .flags_in(flags_r), .flags_we(flags_we), .flags_out(flags_out),
        .done(done), .illegal(illegal)
    );

    logic [7:0] rf_m  [8];
    logic [7:0] mem_m [256];
    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    assign rf_rd_data = rf_m[rf_rd_sel];

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rf_wr_en)  rf_m[rf_wr_sel] = rf_wr_data;
        if (mem_wr_en) mem_m[mem_addr[7:0]] = mem_wdata;
        if (flags_we)  flags_r = flags_out;
        if (mem_rd_en) mem_rdata <= mem_m[mem_addr[7:0]];
    end

    typedef struct {
        logic        bad;
        logic        mem;
        logic        wr;
        logic        fwe;
        logic [7:0]  val;
        logic [7:0]  flg;
        logic [2:0]  sel;
        logic [15:0] addr;
        int          t0;
        int          lat;
        logic [7:0]  op;
    } exp_t;

    exp_t exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] fl(input logic z, input logic n,
                                      input logic h, input logic c);
        return {z, n, h, c, 4'b0000};
    endfunction

    // Scoreboard driver: compute expectation from the requirements, push, start.
    task automatic do_op(input logic [7:0] s, input logic [7:0] v,
                         input logic [7:0] fin, input logic [15:0] a);
        exp_t e;
        logic [2:0] b;
        b = s[5:3];
        e.op  = s;
        e.sel = s[2:0];
        e.mem = (s[2:0] == 3'd6);
        e.addr = a;
        e.bad = 1'b0; e.wr = 1'b0; e.fwe = 1'b0; e.val = v; e.flg = 8'h00;
        if (s[7:6] == 2'b00) begin
            if (s[5:3] == 3'b100) begin        // R2
                e.val = {v[6:0], 1'b0}; e.wr = 1; e.fwe = 1;
                e.flg = fl(e.val == 0, 0, 0, v[7]);
            end else if (s[5:3] == 3'b101) begin // R3
                e.val = {v[7], v[7:1]}; e.wr = 1; e.fwe = 1;
                e.flg = fl(e.val == 0, 0, 0, v[0]);
            end else if (s[5:3] == 3'b111) begin // R4
                e.val = {1'b0, v[7:1]}; e.wr = 1; e.fwe = 1;
                e.flg = fl(e.val == 0, 0, 0, v[0]);
            end else begin
                e.bad = 1'b1;                   // R10
            end
        end else if (s[7:6] == 2'b01) begin     // R6
            e.fwe = 1; e.flg = fl(!v[b], 0, 1, fin[4]);
        end else if (s[7:6] == 2'b10) begin     // R7
            e.wr = 1; e.val = v & ~(8'd1 << b);
        end else begin
            e.wr = 1; e.val = v | (8'd1 << b);
        end
        e.lat = (e.mem && !e.bad) ? 3 : 1;
        @(negedge clk);
        hl = a;
        flags_r = fin;
        if (s[2:0] == 3'd6) mem_m[a[7:0]] = v;
        else rf_m[s[2:0]] = v;
        subop = s;
        start = 1'b1;
        e.t0 = cyc;
        exp_q.push_back(e);
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_rd_en)
                chk(mem_addr == hl, "R9", "read address", mem_addr, hl);
            if ((rf_wr_en || mem_wr_en || flags_we) && !done)
                chk(1'b0, "R8", "write strobe without done", 16'h1, 16'h0);
            if (done || illegal) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected completion", 16'h1, 16'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(illegal == e.bad, "R10", $sformatf("illegal op=%h", e.op), 16'(illegal), 16'(e.bad));
                    chk(done == !e.bad, "R10", $sformatf("done op=%h", e.op), 16'(done), 16'(!e.bad));
                    chk(cyc - e.t0 == e.lat, e.mem ? "R9" : "R8",
                        $sformatf("latency op=%h", e.op), 16'(cyc - e.t0), 16'(e.lat));
                    chk(rf_wr_en == (e.wr && !e.mem && !e.bad), "R1",
                        $sformatf("rf_wr_en op=%h", e.op), 16'(rf_wr_en), 16'(e.wr && !e.mem));
                    chk(mem_wr_en == (e.wr && e.mem && !e.bad), "R9",
                        $sformatf("mem_wr_en op=%h", e.op), 16'(mem_wr_en), 16'(e.wr && e.mem));
                    chk(flags_we == (e.fwe && !e.bad), "R7",
                        $sformatf("flags_we op=%h", e.op), 16'(flags_we), 16'(e.fwe));
                    if (rf_wr_en && !e.mem) begin
                        chk(rf_wr_sel == e.sel, "R1", $sformatf("rf_wr_sel op=%h", e.op), 16'(rf_wr_sel), 16'(e.sel));
                        chk(rf_wr_data == e.val, "R2", $sformatf("rf data op=%h", e.op), 16'(rf_wr_data), 16'(e.val));
                    end
                    if (mem_wr_en && e.mem) begin
                        chk(mem_addr == e.addr, "R9", $sformatf("mem addr op=%h", e.op), mem_addr, e.addr);
                        chk(mem_wdata == e.val, "R9", $sformatf("mem data op=%h", e.op), 16'(mem_wdata), 16'(e.val));
                    end
                    if (flags_we && e.fwe)
                        chk(flags_out == e.flg, "R5", $sformatf("flags op=%h", e.op), 16'(flags_out), 16'(e.flg));
                end
            end
        end
    end

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] lf;
        lf = 8'h5A;
        for (int i = 0; i < 8; i++) rf_m[i] = 8'h00;
        for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(!done && !illegal && !rf_wr_en && !mem_wr_en && !mem_rd_en && !flags_we,
            "R11", "strobes after reset",
            16'({done, illegal, rf_wr_en, mem_wr_en, mem_rd_en, flags_we}), 16'h0);

        // R2 directed: result becomes zero, carry out
        do_op(8'h20, 8'h80, 8'h00, 16'hC010);
        do_op(8'h27, 8'h41, 8'h10, 16'hC010);
        do_op(8'h26, 8'hC3, 8'h00, 16'hC020);
        // R3 sign kept
        do_op(8'h28, 8'h81, 8'h00, 16'hC011);
        do_op(8'h2E, 8'h01, 8'h00, 16'hC021);
        do_op(8'h2F, 8'h00, 8'h10, 16'hC021);
        // R4 zero fill
        do_op(8'h38, 8'h01, 8'h00, 16'hC012);
        do_op(8'h3E, 8'hFE, 8'h10, 16'hC022);
        // R6 test with carry in 0 and 1, bit set and clear
        do_op(8'h7F, 8'h80, 8'h10, 16'hC013);
        do_op(8'h47, 8'hFE, 8'h00, 16'hC013);
        do_op(8'h76, 8'h40, 8'h10, 16'hC023);
        do_op(8'h66, 8'h00, 8'h00, 16'hC023);
        // R7 clear/set every bit index on memory
        for (int b = 0; b < 8; b++) begin
            do_op(8'h86 | 8'(b << 3), 8'hFF, 8'h10, 16'hC030 + 16'(b));
            do_op(8'hC6 | 8'(b << 3), 8'h00, 8'h00, 16'hC040 + 16'(b));
        end
        // R10 illegal codes, including a memory slot
        do_op(8'h00, 8'h33, 8'h10, 16'hC050);
        do_op(8'h06, 8'h33, 8'h10, 16'hC050);
        do_op(8'h37, 8'h33, 8'h10, 16'hC050);
        do_op(8'h1A, 8'h33, 8'h10, 16'hC050);
        // R1 full sweep of sub-opcodes with changing operands
        for (int s = 0; s < 256; s++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            do_op(8'(s), lf, (s % 3 == 0) ? 8'h10 : 8'h00, 16'hC100 + 16'(s[5:0]));
        end
        repeat (6) @(negedge clk);
        chk(exp_q.size() == 0, "R8", "scoreboard drained", 16'(exp_q.size()), 16'h0);
        summary();
        $finish;
    end
endmodule